// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog timer that sits on a simple word-addressed peripheral bus. Software picks a period from a table of powers of two, sets a sticky enable bit, and must then write a fixed key byte to a restart register before each period runs out. If the count reaches its end, the block responds in one of two ways. In direct mode it asserts a system reset pulse at once. In two-stage mode the first expiry raises an interrupt, and a further expiry with no restart in between asserts the reset pulse.

The pending interrupt is cleared when software reads a dedicated clear register or writes a valid restart. An external pause request freezes the count, but only while the pause-enable input is also high. Once enabled, the counter keeps running: after each expiry it reloads and starts over. Only the block reset turns it off.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the enable and mode bits are 0, the timeout code is 0, the counter reads 0, and `wdt_irq` and `wdt_sys_rst` are low.
- R2: Writing the control register (address 0) with bit 0 set enables the timer and loads the counter with the current period minus one. The counter then decrements by one per cycle. Writing 0 to bit 0 never clears the enable.
- R3: With timeout code n (address 1, bits 3:0), the period is P = 2^(BASE_SHIFT+n) cycles. An expiry takes effect exactly P cycles after the enable or restart that loaded the counter.
- R4: A write to the restart register (address 2) whose low byte is 0x76 reloads the counter with P-1 and clears a pending interrupt, provided the timer is enabled. Any other byte is ignored, and so is a restart while the timer is disabled.
- R5: With control bit 1 at 0 (direct mode), an expiry starts a reset pulse and never raises `wdt_irq`.
- R6: With control bit 1 at 1 (two-stage mode), an expiry with no interrupt pending raises `wdt_irq`. An expiry while the interrupt is still pending starts a reset pulse instead.
- R7: Reading the clear register (address 5) returns the interrupt state in bit 0 and clears the pending interrupt. The counter is not affected, and the next expiry counts as a first stage again.
- R8: `wdt_sys_rst` stays high for exactly RST_LEN (8) consecutive cycles per expiry that triggers a reset.
- R9: The counter holds its value while `pause_en` and `pause_req` are both high. Either one alone does not stop the count.
- R10: Reads return the control register as {mode, enable} in bits 1:0, the timeout code in bits 3:0 (upper written bits dropped), the counter value at address 3, and status at address 4 with the interrupt in bit 0 and the enable in bit 1. The restart register reads as 0.
- R11: After an expiry the counter reloads with P-1 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the access |
| pause_en | input | 1 | Allows the pause request to freeze the count |
| pause_req | input | 1 | External pause request |
| wdt_irq | output | 1 | Pending first-stage interrupt |
| wdt_sys_rst | output | 1 | System reset pulse |

## Verification
The assertions check on every cycle that the enable bit never drops, that a keyed restart or a clear read with no coincident expiry leaves the interrupt low, that an interrupt only rises in two-stage mode, and that a reset pulse in two-stage mode only follows a pending interrupt. They also check that every reset pulse is exactly RST_LEN cycles long and that a qualified pause freezes the counter. Only the bench scenarios can show the exact expiry cycle for a given timeout code, that wrong key bytes and disabled restarts leave the count untouched, and that a clear read re-arms the first stage.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_TIMEOUT = 3'd1,
    REG_RESTART = 3'd2,
    REG_COUNT   = 3'd3,
    REG_STATUS  = 3'd4,
    REG_IRQ_CLR = 3'd5
  } wdt_reg_e;

  localparam logic [7:0] RESTART_KEY = 8'h76;
  localparam int         CODE_W      = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_timeout,
  input  logic [DW-1:0]     wdata,
  output logic              en,
  output logic              mode,
  output logic [CODE_W-1:0] code,
  output logic              start
);
  logic              en_q, en_d;
  logic              mode_q, mode_d;
  logic [CODE_W-1:0] code_q, code_d;

  // enable is sticky: only the block reset clears it
  always_comb begin
    en_d   = en_q | wdata[0];
    mode_d = wdata[1];
    code_d = wdata[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= en_d;
        mode_q <= mode_d;
      end
      if (wr_timeout) code_q <= code_d;
    end
  end

  assign start = wr_ctrl & wdata[0] & ~en_q;
  assign en    = en_q;
  assign mode  = mode_q;
  assign code  = code_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 16,
  parameter int CW         = BASE_SHIFT + 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              restart,
  input  logic              en,
  input  logic              hold,
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     cnt,
  output logic              expire
);
  logic [CW-1:0] cnt_q, cnt_d, load;
  logic          cnt_ce;

  always_comb begin
    load   = (CW'(1) << (BASE_SHIFT + int'(code))) - CW'(1);
    expire = en & ~hold & ~start & ~restart & (cnt_q == '0);
    cnt_ce = start | restart | (en & ~hold);
    if (start || restart || expire) cnt_d = load;
    else                            cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_response.sv
module wdt_response #(
  parameter int RST_LEN = 8,
  localparam int PW     = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic mode,
  input  logic clear_irq,
  output logic irq,
  output logic sys_rst
);
  logic          irq_q, irq_d, fire_rst;
  logic [PW-1:0] pls_q, pls_d;

  always_comb begin
    fire_rst = expire & (~mode | irq_q);
    if (expire && mode && !irq_q) irq_d = 1'b1;
    else if (clear_irq)           irq_d = 1'b0;
    else                          irq_d = irq_q;
    if (fire_rst)            pls_d = PW'(RST_LEN);
    else if (pls_q != '0)    pls_d = pls_q - PW'(1);
    else                     pls_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      pls_q <= '0;
    end else begin
      irq_q <= irq_d;
      pls_q <= pls_d;
    end
  end

  assign irq     = irq_q;
  assign sys_rst = (pls_q != '0);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int DW         = 32,
  parameter int BASE_SHIFT = 16,
  parameter int RST_LEN    = 8,
  localparam int CW        = BASE_SHIFT + 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_write,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pause_en,
  input  logic          pause_req,
  output logic          wdt_irq,
  output logic          wdt_sys_rst
);
  logic              wr_ctrl, wr_timeout, key_wr, restart_ok, clr_rd, hold;
  logic              ctrl_en, ctrl_mode, start, expire;
  logic [CODE_W-1:0] code;
  logic [CW-1:0]     cnt;

  always_comb begin
    wr_ctrl    = bus_sel & bus_write & (bus_addr == REG_CTRL);
    wr_timeout = bus_sel & bus_write & (bus_addr == REG_TIMEOUT);
    key_wr     = bus_sel & bus_write & (bus_addr == REG_RESTART)
               & (bus_wdata[7:0] == RESTART_KEY);
    restart_ok = key_wr & ctrl_en;
    clr_rd     = bus_sel & ~bus_write & (bus_addr == REG_IRQ_CLR);
    hold       = pause_en & pause_req;
  end

  wdt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_timeout(wr_timeout),
    .wdata(bus_wdata), .en(ctrl_en), .mode(ctrl_mode), .code(code),
    .start(start)
  );

  wdt_counter #(.BASE_SHIFT(BASE_SHIFT), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(restart_ok),
    .en(ctrl_en), .hold(hold), .code(code), .cnt(cnt), .expire(expire)
  );

  wdt_response #(.RST_LEN(RST_LEN)) u_resp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mode(ctrl_mode),
    .clear_irq(restart_ok | clr_rd), .irq(wdt_irq), .sys_rst(wdt_sys_rst)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL:    bus_rdata = DW'({ctrl_mode, ctrl_en});
      REG_TIMEOUT: bus_rdata = DW'(code);
      REG_COUNT:   bus_rdata = DW'(cnt);
      REG_STATUS:  bus_rdata = DW'({ctrl_en, wdt_irq});
      REG_IRQ_CLR: bus_rdata = DW'(wdt_irq);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int DW      = 32,
  parameter int CW      = 32,
  parameter int RST_LEN = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_write,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          pause_en,
  input logic          pause_req,
  input logic          wdt_irq,
  input logic          wdt_sys_rst,
  input logic          ctrl_en,
  input logic          ctrl_mode,
  input logic [CW-1:0] cnt,
  input logic          expire
);
  logic [7:0] hi_cnt;
  logic       key_wr, clr_rd;

  assign key_wr = bus_sel && bus_write && bus_addr == 3'd2 && bus_wdata[7:0] == 8'h76;
  assign clr_rd = bus_sel && !bus_write && bus_addr == 3'd5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= '0;
    else if (wdt_sys_rst) hi_cnt <= hi_cnt + 8'd1;
    else                  hi_cnt <= '0;
  end

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> ctrl_en);

  assert_key_clears_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && ctrl_en) |=> !wdt_irq);

  assert_irq_only_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> $past(ctrl_mode));

  assert_reset_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wdt_sys_rst) && $past(ctrl_mode)) |-> $past(wdt_irq));

  assert_clear_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !expire) |=> !wdt_irq);

  assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= 8'(RST_LEN));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_sys_rst) |-> hi_cnt == 8'(RST_LEN));

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && pause_en && pause_req && !key_wr) |=> $stable(cnt));
endmodule

bind wdt_timer wdt_timer_chk #(.DW(DW), .CW(CW), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pause_en(pause_en),
  .pause_req(pause_req), .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst),
  .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .cnt(cnt), .expire(expire)
);

// File: tb/sim_wdt_timer.sv
`timescale 1ns/1ps
module sim_wdt_timer;
  localparam int DW = 32;
  localparam int BS = 4;   // period for code 0 is 16 cycles

  logic          clk, rst_n, bus_sel, bus_write, pause_en, pause_req;
  logic [2:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          wdt_irq, wdt_sys_rst;
  int            total, bad;
  logic [DW-1:0] rd;

  wdt_timer #(.DW(DW), .BASE_SHIFT(BS), .RST_LEN(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pause_en(pause_en), .pause_req(pause_req), .wdt_irq(wdt_irq),
    .wdt_sys_rst(wdt_sys_rst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] val;   // write data or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 32'h0,  8'd1},   // R1 control after reset
    '{1'b0, 3'd4, 32'h0,  8'd1},   // R1 status after reset
    '{1'b0, 3'd3, 32'h0,  8'd1},   // R1 counter after reset
    '{1'b1, 3'd1, 32'h12, 8'd10},  // R10 upper code bits dropped
    '{1'b0, 3'd1, 32'h2,  8'd10},
    '{1'b1, 3'd0, 32'h2,  8'd10},  // R10 mode only, still disabled
    '{1'b0, 3'd0, 32'h2,  8'd10},
    '{1'b1, 3'd2, 32'h76, 8'd4},   // R4 restart while disabled
    '{1'b0, 3'd3, 32'h0,  8'd4},
    '{1'b0, 3'd2, 32'h0,  8'd10},  // R10 restart reads 0
    '{1'b0, 3'd5, 32'h0,  8'd7}    // R7 nothing pending
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    total = 0; bad = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; pause_en = 1'b0; pause_req = 1'b0;
    repeat (3) @(negedge clk);
    check({30'b0, wdt_irq, wdt_sys_rst}, 32'h0, "R1 outputs in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bwrite(VECS[i].addr, VECS[i].val);
      else begin
        bread(VECS[i].addr, rd);
        check(rd, VECS[i].val, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end

    // two-stage mode, period 16
    bwrite(3'd1, 32'h0);
    bwrite(3'd0, 32'h3);
    repeat (15) @(negedge clk);
    check({31'b0, wdt_irq}, 32'h0, "R3 no irq before period");
    @(negedge clk);
    check({31'b0, wdt_irq}, 32'h1, "R3 R6 irq at period");
    check({31'b0, wdt_sys_rst}, 32'h0, "R6 no reset on first stage");
    bread(3'd5, rd);
    check(rd, 32'h1, "R7 clear read returns irq");
    check({31'b0, wdt_irq}, 32'h0, "R7 irq cleared by read");
    bread(3'd3, rd);
    check(rd, 32'd12, "R7 R11 counter keeps running");
    bwrite(3'd2, 32'h75);
    bread(3'd3, rd);
    check(rd, 32'd8, "R4 wrong key ignored");
    repeat (8) @(negedge clk);
    check({30'b0, wdt_sys_rst, wdt_irq}, 32'h1, "R7 re-armed first stage");
    bwrite(3'd2, 32'hA576);
    check({31'b0, wdt_irq}, 32'h0, "R4 key clears irq");
    bread(3'd3, rd);
    check(rd, 32'd14, "R4 key reloads counter");
    repeat (13) @(negedge clk);
    check({31'b0, wdt_irq}, 32'h0, "R4 no irq before reloaded period");
    @(negedge clk);
    check({31'b0, wdt_irq}, 32'h1, "R6 irq again");
    repeat (15) @(negedge clk);
    check({31'b0, wdt_sys_rst}, 32'h0, "R6 no reset early");
    @(negedge clk);
    check({31'b0, wdt_sys_rst}, 32'h1, "R6 second expiry resets");
    n = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wdt_sys_rst) n++;
      else break;
    end
    check(n, 32'd8, "R8 reset pulse length");

    // direct mode and pause after a fresh reset
    rst_n = 1'b0;
    @(negedge clk);
    check({30'b0, wdt_irq, wdt_sys_rst}, 32'h0, "R1 outputs after second reset");
    rst_n = 1'b1;
    bread(3'd0, rd);
    check(rd, 32'h0, "R1 control cleared");
    bwrite(3'd1, 32'h0);
    bwrite(3'd0, 32'h1);
    pause_en = 1'b1;
    bread(3'd3, rd);
    check(rd, 32'd14, "R2 R9 loaded and counting with pause_en alone");
    pause_req = 1'b1;
    bread(3'd3, rd);
    check(rd, 32'd13, "R9 held by pause");
    pause_en = 1'b0;
    bread(3'd3, rd);
    check(rd, 32'd12, "R9 pause_req alone does not hold");
    pause_req = 1'b0;
    repeat (11) @(negedge clk);
    check({31'b0, wdt_sys_rst}, 32'h0, "R5 no reset early");
    @(negedge clk);
    check({30'b0, wdt_irq, wdt_sys_rst}, 32'h1, "R5 direct reset, no irq");
    bwrite(3'd0, 32'h0);
    bread(3'd0, rd);
    check(rd, 32'h1, "R2 enable stays set");
    bread(3'd4, rd);
    check(rd, 32'h2, "R10 status enable and no irq");
    finish_run();
  end
endmodule